// File: doc/BRIEF.md
# Self-routing Banyan cell network

The block is a self-routing switching fabric for fixed-length cells. Every clock, each of its PORTS input lines may carry one cell made of a valid bit, a destination port number and a payload word. The cells pass through log2(PORTS) columns of two-by-two switching elements. Each column has PORTS/2 elements, so the default eight-port build has three columns of four. Each element reads one destination bit of the cells it holds and sets itself straight ("bar") or swapped ("cross"). No central scheduler takes part in routing.

The fabric holds no cells. When two cells at one element need opposite settings, the cell on the lower-numbered line wins. The other cell takes the remaining output and carries a misroute flag from then on. A flagged cell still leaves the fabric on some output, so nothing is dropped. In later columns it never decides an element setting, which leaves the internal links to cells that can still arrive correctly. Each column is registered, so results appear a fixed number of clocks after the cells enter. Each output presents valid, misroute flag, destination and payload, and logic downstream can count, resend or discard the flagged cells.

Top module: `banyan_cell_fabric`

## Requirements
- R1: A cell set presented at the inputs on one clock edge appears at the outputs exactly 3 clock edges later (one per column). A new cell set is accepted on every clock.
- R2: A cell that meets no live cell needing the opposite setting leaves on the output port equal to its destination, with its misroute flag clear and its destination and payload unchanged. For port p, the destination is in_dst[p*3 +: 3] and the payload is in_data[p*16 +: 16]; out_dst and out_data use the same positions.
- R3: Column j pairs line l (bit j clear) with line l+2^j. The element sets itself from the live cell on line l, choosing the setting that moves that cell to the line whose bit j equals its destination bit j. Only when line l holds no live cell does the cell on line l+2^j decide. So on a conflict the lower-numbered line wins.
- R4: The losing cell of a conflict takes the other output and has its misroute flag set. The flag stays set until the cell leaves, and the cell is never dropped.
- R5: An invalid cell or a flagged cell never decides an element setting. An element with no live cell stays straight, so each cell stays on its line.
- R6: Every valid input cell appears on exactly one output 3 clocks later, and the number of valid outputs equals the number of valid inputs of that cell set.
- R7: A valid output whose misroute flag is clear carries a destination equal to its own port index.
- R8: out_miss is never set on a port whose out_vld is clear.
- R9: While rst_n is low, all outputs are invalid and unflagged, and cells driven during reset never appear at the outputs.
- R10: A full load in which every input i sends to destination i XOR m, for any constant m, passes with no misroute flags, and each cell reaches port i XOR m.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cell slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | PORTS | Per-line cell present |
| in_dst | input | PORTS*log2(PORTS) | Per-line destination port, line p at p*log2(PORTS) |
| in_data | input | PORTS*PAYLOAD_W | Per-line payload, line p at p*PAYLOAD_W |
| out_vld | output | PORTS | Per-port cell present |
| out_miss | output | PORTS | Per-port misroute flag |
| out_dst | output | PORTS*log2(PORTS) | Destination carried by the cell on each port |
| out_data | output | PORTS*PAYLOAD_W | Payload carried by the cell on each port |

## Verification
The bench builds the fabric with PORTS = 8 and PAYLOAD_W = 16. With eight ports, every column sees conflicts, and a flagged cell can share an element with a live cell in a later column, which is where the no-contend rule shows. A 16-bit payload lets each cell carry a unique tag, so the bench can follow every cell from input to output and show that none is lost or duplicated. The bench also sweeps all 64 input-to-output pairs and all eight XOR mappings. Random loads are compared each clock against a behavioural priority model.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

   // Setting of one two-by-two element
   typedef enum logic {
      SW_BAR   = 1'b0,
      SW_CROSS = 1'b1
   } sw_state_e;

   // Lower-numbered line served by element 'elem' of column 'col':
   // insert a zero at bit position 'col' of the element index.
   function automatic int upper_line(input int elem, input int col);
      int low_mask;
      low_mask = (1 << col) - 1;
      return ((elem >> col) << (col + 1)) | (elem & low_mask);
   endfunction

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem #(
   parameter int ADDR_W    = 3,
   parameter int PAYLOAD_W = 16,
   parameter int COL       = 0
) (
   input  logic                 up_vld,
   input  logic                 up_miss,
   input  logic [ADDR_W-1:0]    up_dst,
   input  logic [PAYLOAD_W-1:0] up_data,
   input  logic                 dn_vld,
   input  logic                 dn_miss,
   input  logic [ADDR_W-1:0]    dn_dst,
   input  logic [PAYLOAD_W-1:0] dn_data,
   output logic                 lo_vld,
   output logic                 lo_miss,
   output logic [ADDR_W-1:0]    lo_dst,
   output logic [PAYLOAD_W-1:0] lo_data,
   output logic                 hi_vld,
   output logic                 hi_miss,
   output logic [ADDR_W-1:0]    hi_dst,
   output logic [PAYLOAD_W-1:0] hi_data
);
   import banyan_pkg::*;

   if (COL < 0 || COL >= ADDR_W) begin : g_bad_col
      $error("banyan_elem: COL out of destination range");
   end

   sw_state_e sel;
   logic      up_live;
   logic      dn_live;
   logic      lo_m;
   logic      hi_m;

   assign up_live = up_vld & ~up_miss;
   assign dn_live = dn_vld & ~dn_miss;

   // Lower-numbered line decides first; flagged or empty cells never decide
   always_comb begin
      if (up_live)
         sel = up_dst[COL] ? SW_CROSS : SW_BAR;
      else if (dn_live)
         sel = dn_dst[COL] ? SW_BAR : SW_CROSS;
      else
         sel = SW_BAR;
   end

   always_comb begin
      if (sel == SW_CROSS) begin
         lo_vld  = dn_vld;
         lo_m    = dn_miss;
         lo_dst  = dn_dst;
         lo_data = dn_data;
         hi_vld  = up_vld;
         hi_m    = up_miss;
         hi_dst  = up_dst;
         hi_data = up_data;
      end else begin
         lo_vld  = up_vld;
         lo_m    = up_miss;
         lo_dst  = up_dst;
         lo_data = up_data;
         hi_vld  = dn_vld;
         hi_m    = dn_miss;
         hi_dst  = dn_dst;
         hi_data = dn_data;
      end
      // a valid cell landing on the line whose bit disagrees has lost
      lo_miss = lo_m | (lo_vld & lo_dst[COL]);
      hi_miss = hi_m | (hi_vld & ~hi_dst[COL]);
   end

endmodule

// File: rtl/banyan_column.sv
module banyan_column #(
   parameter int PORTS     = 8,
   parameter int ADDR_W    = 3,
   parameter int PAYLOAD_W = 16,
   parameter int COL       = 0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [PORTS-1:0]                     in_vld,
   input  logic [PORTS-1:0]                     in_miss,
   input  logic [PORTS-1:0][ADDR_W-1:0]         in_dst,
   input  logic [PORTS-1:0][PAYLOAD_W-1:0]      in_data,
   output logic [PORTS-1:0]                     q_vld,
   output logic [PORTS-1:0]                     q_miss,
   output logic [PORTS-1:0][ADDR_W-1:0]         q_dst,
   output logic [PORTS-1:0][PAYLOAD_W-1:0]      q_data
);
   localparam int ELEMS = PORTS / 2;
   localparam int SPAN  = 1 << COL;

   logic [PORTS-1:0]                nx_vld;
   logic [PORTS-1:0]                nx_miss;
   logic [PORTS-1:0][ADDR_W-1:0]    nx_dst;
   logic [PORTS-1:0][PAYLOAD_W-1:0] nx_data;

   for (genvar k = 0; k < ELEMS; k++) begin : g_elem
      localparam int UP = banyan_pkg::upper_line(k, COL);
      localparam int DN = UP + SPAN;
      banyan_elem #(
         .ADDR_W   (ADDR_W),
         .PAYLOAD_W(PAYLOAD_W),
         .COL      (COL)
      ) u_elem (
         .up_vld (in_vld[UP]),
         .up_miss(in_miss[UP]),
         .up_dst (in_dst[UP]),
         .up_data(in_data[UP]),
         .dn_vld (in_vld[DN]),
         .dn_miss(in_miss[DN]),
         .dn_dst (in_dst[DN]),
         .dn_data(in_data[DN]),
         .lo_vld (nx_vld[UP]),
         .lo_miss(nx_miss[UP]),
         .lo_dst (nx_dst[UP]),
         .lo_data(nx_data[UP]),
         .hi_vld (nx_vld[DN]),
         .hi_miss(nx_miss[DN]),
         .hi_dst (nx_dst[DN]),
         .hi_data(nx_data[DN])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= '0;
         q_miss <= '0;
         q_dst  <= '0;
         q_data <= '0;
      end else begin
         q_vld  <= nx_vld;
         q_miss <= nx_miss;
         q_dst  <= nx_dst;
         q_data <= nx_data;
      end
   end

endmodule

// File: rtl/banyan_cell_fabric.sv
module banyan_cell_fabric #(
   parameter int PORTS     = 8,
   parameter int PAYLOAD_W = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [PORTS-1:0]                   in_vld,
   input  logic [PORTS*$clog2(PORTS)-1:0]     in_dst,
   input  logic [PORTS*PAYLOAD_W-1:0]         in_data,
   output logic [PORTS-1:0]                   out_vld,
   output logic [PORTS-1:0]                   out_miss,
   output logic [PORTS*$clog2(PORTS)-1:0]     out_dst,
   output logic [PORTS*PAYLOAD_W-1:0]         out_data
);
   localparam int ADDR_W = $clog2(PORTS);
   localparam int STAGES = ADDR_W;

   if (PORTS < 2 || (PORTS & (PORTS - 1)) != 0) begin : g_bad_ports
      $error("banyan_cell_fabric: PORTS must be a power of two of at least 2");
   end
   if (PAYLOAD_W < 1) begin : g_bad_payload
      $error("banyan_cell_fabric: PAYLOAD_W must be positive");
   end

   logic [STAGES:0][PORTS-1:0]                s_vld;
   logic [STAGES:0][PORTS-1:0]                s_miss;
   logic [STAGES:0][PORTS-1:0][ADDR_W-1:0]    s_dst;
   logic [STAGES:0][PORTS-1:0][PAYLOAD_W-1:0] s_data;

   assign s_vld[0]  = in_vld;
   assign s_miss[0] = '0;

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign s_dst[0][p]                       = in_dst[p*ADDR_W +: ADDR_W];
      assign s_data[0][p]                      = in_data[p*PAYLOAD_W +: PAYLOAD_W];
      assign out_dst[p*ADDR_W +: ADDR_W]       = s_dst[STAGES][p];
      assign out_data[p*PAYLOAD_W +: PAYLOAD_W] = s_data[STAGES][p];
   end

   for (genvar c = 0; c < STAGES; c++) begin : g_col
      banyan_column #(
         .PORTS    (PORTS),
         .ADDR_W   (ADDR_W),
         .PAYLOAD_W(PAYLOAD_W),
         .COL      (c)
      ) u_col (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_vld (s_vld[c]),
         .in_miss(s_miss[c]),
         .in_dst (s_dst[c]),
         .in_data(s_data[c]),
         .q_vld  (s_vld[c+1]),
         .q_miss (s_miss[c+1]),
         .q_dst  (s_dst[c+1]),
         .q_data (s_data[c+1])
      );
   end

   assign out_vld  = s_vld[STAGES];
   assign out_miss = s_miss[STAGES];

endmodule

// File: rtl/banyan_fabric_chk.sv
module banyan_fabric_chk #(
   parameter int PORTS  = 8,
   parameter int ADDR_W = 3,
   parameter int STAGES = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [PORTS-1:0]          in_vld,
   input logic [PORTS-1:0]          out_vld,
   input logic [PORTS-1:0]          out_miss,
   input logic [PORTS*ADDR_W-1:0]   out_dst
);
   // edges since reset release, saturating at the pipeline depth
   int unsigned warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         warm <= 0;
      else if (warm < STAGES)
         warm <= warm + 1;
   end

   AST_CELL_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (warm >= STAGES) |-> ($countones(out_vld) == $past($countones(in_vld), STAGES))) else $error("cell count changed across fabric"); // R6

   AST_LONE_CELL: assert property (@(posedge clk) disable iff (!rst_n) (warm >= STAGES && $past($countones(in_vld), STAGES) <= 1) |-> (out_miss == '0)) else $error("lone cell flagged"); // R2

   AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) ((out_miss & ~out_vld) == '0)) else $error("flag on empty port"); // R8

   AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (out_vld == '0 && out_miss == '0)) else $error("outputs busy out of reset"); // R9

   for (genvar p = 0; p < PORTS; p++) begin : g_home
      AST_UNFLAGGED_HOME: assert property (@(posedge clk) disable iff (!rst_n) (out_vld[p] && !out_miss[p]) |-> (out_dst[p*ADDR_W +: ADDR_W] == ADDR_W'(p))) else $error("unflagged cell on wrong port"); // R7
   end

endmodule

bind banyan_cell_fabric banyan_fabric_chk #(
   .PORTS (PORTS),
   .ADDR_W(ADDR_W),
   .STAGES(STAGES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .out_vld (out_vld),
   .out_miss(out_miss),
   .out_dst (out_dst)
);

// File: tb/sim_banyan_cell_fabric.sv
module sim_banyan_cell_fabric;
   localparam int P   = 8;
   localparam int A   = 3;
   localparam int W   = 16;
   localparam int LAT = 3;

   typedef struct packed {
      logic [P-1:0]   vld;
      logic [P-1:0]   miss;
      logic [P*A-1:0] dst;
      logic [P*W-1:0] data;
      logic [P-1:0]   inv;
      logic [P*W-1:0] inx;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [P-1:0]   in_vld  = '0;
   logic [P*A-1:0] in_dst  = '0;
   logic [P*W-1:0] in_data = '0;
   logic [P-1:0]   out_vld;
   logic [P-1:0]   out_miss;
   logic [P*A-1:0] out_dst;
   logic [P*W-1:0] out_data;

   int   n_chk  = 0;
   int   n_fail = 0;
   int   seq    = 1;
   exp_t expq[$];

   always #5 clk = ~clk;

   banyan_cell_fabric #(.PORTS(P), .PAYLOAD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
      .out_vld(out_vld), .out_miss(out_miss), .out_dst(out_dst), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural priority model: each column, lower line's live cell picks first
   function automatic exp_t model(input logic [P-1:0] v, input logic [P*A-1:0] d,
                                  input logic [P*W-1:0] x, input logic live_rst);
      exp_t e;
      int lv[P]; int lm[P]; int ld[P]; int lx[P];
      int nv[P]; int nm[P]; int nd[P]; int nx[P];
      e = '0;
      e.inv = v;
      e.inx = x;
      if (!live_rst) begin
         e.inv = '0;
         return e;
      end
      for (int p = 0; p < P; p++) begin
         lv[p] = int'(v[p]); lm[p] = 0;
         ld[p] = int'(d[p*A +: A]); lx[p] = int'(x[p*W +: W]);
      end
      for (int c = 0; c < A; c++) begin
         for (int l = 0; l < P; l++) begin
            if (((l >> c) & 1) == 0) begin
               int h; int a_to; int b_to; bit al; bit bl;
               h  = l | (1 << c);
               al = (lv[l] != 0) && (lm[l] == 0);
               bl = (lv[h] != 0) && (lm[h] == 0);
               if (al)      a_to = ((ld[l] >> c) & 1) != 0 ? h : l;
               else if (bl) a_to = ((ld[h] >> c) & 1) != 0 ? l : h;
               else         a_to = l;
               b_to = (a_to == l) ? h : l;
               nv[a_to] = lv[l]; nm[a_to] = lm[l]; nd[a_to] = ld[l]; nx[a_to] = lx[l];
               nv[b_to] = lv[h]; nm[b_to] = lm[h]; nd[b_to] = ld[h]; nx[b_to] = lx[h];
            end
         end
         for (int t = 0; t < P; t++) begin
            if (nv[t] != 0 && ((nd[t] >> c) & 1) != ((t >> c) & 1)) nm[t] = 1;
            lv[t] = nv[t]; lm[t] = nm[t]; ld[t] = nd[t]; lx[t] = nx[t];
         end
      end
      for (int p = 0; p < P; p++) begin
         e.vld[p] = lv[p] != 0;
         e.miss[p] = lm[p] != 0;
         if (lv[p] != 0) begin
            e.dst[p*A +: A]  = A'(ld[p]);
            e.data[p*W +: W] = W'(lx[p]);
         end
      end
      return e;
   endfunction

   task automatic compare(input exp_t e);
      for (int p = 0; p < P; p++) begin
         chk(out_vld[p] == e.vld[p], "R1", $sformatf("vld port %0d", p), out_vld[p], e.vld[p]);
         if (e.vld[p] && out_vld[p]) begin
            chk(out_miss[p] == e.miss[p], "R4", $sformatf("miss port %0d", p), out_miss[p], e.miss[p]);
            chk(out_data[p*W +: W] == e.data[p*W +: W], "R2", $sformatf("data port %0d", p),
                out_data[p*W +: W], e.data[p*W +: W]);
            chk(out_dst[p*A +: A] == e.dst[p*A +: A], "R2", $sformatf("dst port %0d", p),
                out_dst[p*A +: A], e.dst[p*A +: A]);
         end
         if (out_vld[p] && !out_miss[p])
            chk(out_dst[p*A +: A] == A'(p), "R7", $sformatf("home port %0d", p), out_dst[p*A +: A], p);
         chk(!(out_miss[p] && !out_vld[p]), "R8", $sformatf("flag w/o valid port %0d", p), out_miss[p], 0);
      end
      chk($countones(out_vld) == $countones(e.inv), "R6", "cell count", $countones(out_vld), $countones(e.inv));
      for (int p = 0; p < P; p++) begin
         if (e.inv[p]) begin
            int hits;
            hits = 0;
            for (int q = 0; q < P; q++)
               if (out_vld[q] && out_data[q*W +: W] == e.inx[p*W +: W]) hits++;
            chk(hits == 1, "R6", $sformatf("copies of cell from input %0d", p), hits, 1);
         end
      end
   endtask

   // one slot: check the result due now, then drive the next cell set
   task automatic step(input logic r, input logic [P-1:0] v, input logic [P*A-1:0] d,
                       input logic [P*W-1:0] x);
      @(negedge clk);
      if (expq.size() == LAT) compare(expq.pop_front());
      rst_n   = r;
      in_vld  = v;
      in_dst  = d;
      in_data = x;
      expq.push_back(model(v, d, x, r));
   endtask

   task automatic idle();
      step(1'b1, '0, '0, '0);
   endtask

   // drive one cell set, then drain; returns with its result on the outputs
   task automatic send(input logic [P-1:0] v, input logic [P*A-1:0] d, input logic [P*W-1:0] x);
      step(1'b1, v, d, x);
      idle();
      idle();
      chk(out_vld == '0, "R1", "outputs before latency", out_vld, 0);
      idle();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [P-1:0]   v;
      logic [P*A-1:0] d;
      logic [P*W-1:0] x;
      rst_n = 1'b0;

      // R9: reset phase with live cells on the inputs
      for (int k = 0; k < 4; k++) begin
         d = '0; x = '0;
         for (int i = 0; i < P; i++) begin d[i*A +: A] = A'(i); x[i*W +: W] = W'(16'hA000 + i); end
         step(1'b0, '1, d, x);
      end
      chk(out_vld == '0, "R9", "valid during reset", out_vld, 0);
      chk(out_miss == '0, "R9", "flag during reset", out_miss, 0);
      idle();
      idle();
      idle();
      chk(out_vld == '0, "R9", "reset-time cells leaked", out_vld, 0);

      // R2 / R1: every single input-to-output pair
      for (int i = 0; i < P; i++) begin
         for (int o = 0; o < P; o++) begin
            v = '0; d = '0; x = '0;
            v[i] = 1'b1; d[i*A +: A] = A'(o); x[i*W +: W] = W'(seq);
            send(v, d, x);
            chk(out_vld == (P'(1) << o), "R2", $sformatf("lone %0d->%0d port", i, o), out_vld, P'(1) << o);
            chk(out_miss == '0, "R2", "lone cell flag", out_miss, 0);
            chk(out_data[o*W +: W] == W'(seq), "R2", "lone payload", out_data[o*W +: W], seq);
            seq++;
         end
      end

      // R10: XOR mappings under full load
      for (int m = 0; m < P; m++) begin
         d = '0; x = '0;
         for (int i = 0; i < P; i++) begin
            d[i*A +: A] = A'(i ^ m); x[i*W +: W] = W'(seq + i);
         end
         send('1, d, x);
         chk(out_miss == '0, "R10", $sformatf("xor %0d flags", m), out_miss, 0);
         for (int i = 0; i < P; i++)
            chk(out_data[(i ^ m)*W +: W] == W'(seq + i), "R10", $sformatf("xor %0d cell %0d", m, i),
                out_data[(i ^ m)*W +: W], seq + i);
         seq += P;
      end

      // R3: lines 0 and 1 both to port 1, lower line wins
      v = '0; d = '0; x = '0;
      v[0] = 1'b1; d[0 +: A] = A'(1); x[0 +: W] = W'(seq);
      v[1] = 1'b1; d[A +: A] = A'(1); x[W +: W] = W'(seq + 1);
      send(v, d, x);
      chk(out_vld[1] && !out_miss[1] && out_data[W +: W] == W'(seq), "R3", "winner on port 1",
          out_data[W +: W], seq);
      chk(out_vld[0] && out_miss[0] && out_data[0 +: W] == W'(seq + 1), "R3", "loser on port 0",
          out_data[0 +: W], seq + 1);
      seq += 2;

      // R4: all inputs to port 0; only line 0 arrives unflagged
      d = '0; x = '0;
      for (int i = 0; i < P; i++) x[i*W +: W] = W'(seq + i);
      send('1, d, x);
      chk(out_vld == '1, "R4", "all cells kept", out_vld, '1);
      chk(out_miss == ~P'(1), "R4", "flag pattern", out_miss, ~P'(1));
      chk(out_data[0 +: W] == W'(seq), "R4", "port 0 payload", out_data[0 +: W], seq);
      seq += P;

      // R5: a flagged cell on the lower line must not beat a live cell
      v = '0; d = '0; x = '0;
      v[0] = 1'b1; d[0*A +: A] = A'(0); x[0*W +: W] = W'(seq);
      v[1] = 1'b1; d[1*A +: A] = A'(0); x[1*W +: W] = W'(seq + 1);
      v[3] = 1'b1; d[3*A +: A] = A'(1); x[3*W +: W] = W'(seq + 2);
      send(v, d, x);
      chk(out_vld[1] && !out_miss[1] && out_data[W +: W] == W'(seq + 2), "R5", "live cell reaches port 1",
          out_data[W +: W], seq + 2);
      chk(out_vld[3] && out_miss[3] && out_data[3*W +: W] == W'(seq + 1), "R5", "flagged cell goes straight to 3",
          out_data[3*W +: W], seq + 1);
      chk(out_vld == 8'b0000_1011, "R5", "occupied ports", out_vld, 8'b0000_1011);
      seq += 3;

      // R4 R6 R7 R1: random loads checked against the model every clock
      for (int t = 0; t < 3000; t++) begin
         v = '0; d = '0; x = '0;
         for (int i = 0; i < P; i++) begin
            if (($urandom % 8) < 5) begin
               v[i] = 1'b1;
               d[i*A +: A] = A'($urandom % P);
               x[i*W +: W] = W'(seq);
               seq++;
            end
         end
         step(1'b1, v, d, x);
      end
      idle();
      idle();
      idle();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule